// File: doc/BRIEF.md
# Token FIFO Controller with Pulse-Fired Hops

The block is a linear first-in first-out buffer built as a chain of slots joined by hops. Each slot stores one data word and a single occupancy bit. Each hop sits between two neighbouring slots and moves a word forward. A hop fires for exactly one cycle, and only when the slot behind it holds a word and the slot ahead of it is vacant. In that cycle the word is copied ahead, the forward slot is marked occupied and the rear slot is marked vacant. The hop then stays quiet for a fixed number of cycles while its firing logic re-arms.

Words enter at slot 0 through a valid/ready handshake and leave from the last slot through a valid/take handshake. A hop learns that its rear slot is occupied through one extra register stage. It sees that its forward slot is vacant directly. As a result, a word advances one slot every two cycles, while a hole (a vacant slot) travels backwards one slot per cycle. The occupancy bits are brought out on a port, with the vacant state encoded as 1.

Top module: `token_fifo_ctrl`

## Requirements
- R1: While reset is asserted, every slot is vacant: `slot_vacant` is all ones, `in_ready` is 1 and `out_valid` is 0.
- R2: Bit k of `slot_vacant` is 0 exactly when slot k holds a word. Slot 0 is at the input side. `in_ready` equals bit 0 and `out_valid` is the inverse of the top bit.
- R3: A hop moves a word into slot k only when slot k-1 holds a word and slot k is vacant. No slot is ever written while it holds a word.
- R4: At the clock edge that ends a hop's pulse, three things happen together. Slot k captures the word of slot k-1, slot k becomes occupied, and slot k-1 becomes vacant. No word is duplicated or lost.
- R5: After a hop fires, it stays idle for `RESET_CYCLES` cycles (default 3) before it may fire again. The pulse never lasts two cycles.
- R6: A word that fills slot k-1 reaches an already vacant slot k two edges later. One word written into an empty buffer raises `out_valid` 2*(SLOTS-1) edges after the edge that accepted it.
- R7: A hole moves backwards one slot per edge through hops that are idle. In a full buffer, one take reasserts `out_valid` on the next edge and raises `in_ready` SLOTS-1 edges after the take edge.
- R8: A word is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_valid` has no effect while `in_ready` is 0.
- R9: A take on an edge where `out_valid` is 1 vacates the last slot. `out_take` has no effect while `out_valid` is 0. `out_data` holds steady while `out_valid` is 1 and no take occurs.
- R10: Words leave in the order they were accepted, with none lost, under any pattern of input and output stalls. The number of occupied slots always equals the number of words accepted minus the number taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A word is offered at the input |
| in_data | input | WIDTH | Offered word |
| in_ready | output | 1 | Slot 0 is vacant and accepts the offered word on this edge |
| out_valid | output | 1 | The last slot holds a word |
| out_take | input | 1 | The consumer removes the word in the last slot on this edge |
| out_data | output | WIDTH | Word held in the last slot |
| slot_vacant | output | SLOTS | Occupancy of every slot, 1 meaning vacant |

## Verification
The assertions assume that `in_valid` and `out_take` stay low while reset is asserted. They also assume that the inputs change only away from the rising clock edge, so that the word count follows the handshakes seen at each edge. The stimulus drives every input on the falling edge and holds both handshakes low until the synchronised reset has been released. Outside reset, the random phases pick `in_valid`, `in_data` and `out_take` freely each cycle, because the block accepts any pattern there, including a valid that drops without being accepted.

// File: rtl/tf_pkg.sv
package tf_pkg;

  // Width of a down-counter that must hold the value `cycles`.
  function automatic int unsigned hold_bits(input int unsigned cycles);
    int unsigned bits;
    bits = $clog2(cycles + 1);
    return (bits < 1) ? 1 : bits;
  endfunction

endpackage

// File: rtl/tf_rst_sync.sv
module tf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tf_slot.sv
// One storage slot: an occupancy bit (1 = vacant) and a data word.
module tf_slot #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_i,
  input  logic             drain_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             vacant_o,
  output logic [WIDTH-1:0] dout_o
);

  logic             vacant_q;
  logic             vacant_d;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;
  logic             data_en;

  always_comb begin
    vacant_d = vacant_q;
    if (fill_i) begin
      vacant_d = 1'b0;
    end else if (drain_i) begin
      vacant_d = 1'b1;
    end
    data_en = fill_i;
    data_d  = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vacant_q <= 1'b1;
      data_q   <= '0;
    end else begin
      vacant_q <= vacant_d;
      if (data_en) begin
        data_q <= data_d;
      end
    end
  end

  assign vacant_o = vacant_q;
  assign dout_o   = data_q;

endmodule

// File: rtl/tf_hop.sv
// Transfer cell between two slots. The rear slot's occupancy is sensed
// through one register (slow forward path); the forward slot's vacancy is
// used directly (fast reverse path). After a one-cycle pulse the cell holds
// off for RESET_CYCLES cycles, which also covers the stale sensed value.
module tf_hop #(
  parameter int unsigned RESET_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pred_vacant_i,
  input  logic succ_vacant_i,
  output logic fire_o
);

  localparam int unsigned     CW   = tf_pkg::hold_bits(RESET_CYCLES);
  localparam logic [CW-1:0]   HOLD = CW'(RESET_CYCLES);
  localparam logic [CW-1:0]   ONE  = CW'(1);

  logic          pred_full_q;
  logic          pred_full_d;
  logic [CW-1:0] hold_q;
  logic [CW-1:0] hold_d;
  logic          armed;

  always_comb begin
    pred_full_d = ~pred_vacant_i;
    armed       = (hold_q == '0);
    fire_o      = pred_full_q & succ_vacant_i & armed;
    if (fire_o) begin
      hold_d = HOLD;
    end else if (!armed) begin
      hold_d = hold_q - ONE;
    end else begin
      hold_d = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_full_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      pred_full_q <= pred_full_d;
      hold_q      <= hold_d;
    end
  end

endmodule

// File: rtl/token_fifo_ctrl.sv
module token_fifo_ctrl #(
  parameter int unsigned SLOTS        = 4,
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned RESET_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_take,
  output logic [WIDTH-1:0] out_data,
  output logic [SLOTS-1:0] slot_vacant
);

  localparam int unsigned LAST = SLOTS - 1;

  logic                        rst_sync_n;
  logic [SLOTS-1:0]            fill;
  logic [SLOTS-1:0]            drain;
  logic [SLOTS-1:0][WIDTH-1:0] slot_data;

  tf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Edge handshakes
  assign in_ready    = slot_vacant[0];
  assign fill[0]     = in_valid & slot_vacant[0];
  assign out_valid   = ~slot_vacant[LAST];
  assign out_data    = slot_data[LAST];
  assign drain[LAST] = out_take & ~slot_vacant[LAST];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == 0) begin : g_head
      tf_slot #(.WIDTH(WIDTH)) i_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .fill_i   (fill[k]),
        .drain_i  (drain[k]),
        .din_i    (in_data),
        .vacant_o (slot_vacant[k]),
        .dout_o   (slot_data[k])
      );
    end else begin : g_body
      tf_slot #(.WIDTH(WIDTH)) i_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .fill_i   (fill[k]),
        .drain_i  (drain[k]),
        .din_i    (slot_data[k-1]),
        .vacant_o (slot_vacant[k]),
        .dout_o   (slot_data[k])
      );

      tf_hop #(.RESET_CYCLES(RESET_CYCLES)) i_hop (
        .clk           (clk),
        .rst_n         (rst_sync_n),
        .pred_vacant_i (slot_vacant[k-1]),
        .succ_vacant_i (slot_vacant[k]),
        .fire_o        (fill[k])
      );

      assign drain[k-1] = fill[k];
    end
  end

endmodule

// File: rtl/tf_checker.sv
module tf_checker #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned WIDTH = 8
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [WIDTH-1:0]            in_data,
  input logic                        out_valid,
  input logic                        out_take,
  input logic [WIDTH-1:0]            out_data,
  input logic [SLOTS-1:0]            slot_vacant,
  input logic [SLOTS-1:0]            fill,
  input logic [SLOTS-1:0][WIDTH-1:0] slot_data
);

  for (genvar k = 1; k < SLOTS; k++) begin : g_hop_chk
    // R3
    a_r3_fire_rule: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fill[k] |-> (!slot_vacant[k-1] && slot_vacant[k]));

    // R4
    a_r4_transfer: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fill[k] |=> (!slot_vacant[k] && slot_vacant[k-1] &&
                   slot_data[k] == $past(slot_data[k-1])));

    // R5
    a_r5_self_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fill[k] |=> !fill[k]);

    // R6
    a_r6_forward_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(slot_vacant[k-1]) |-> !fill[k]);
  end

  // R8
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready) |=> (!slot_vacant[0] && slot_data[0] == $past(in_data)));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_take) |=> (out_valid && $stable(out_data)));

  a_r9_take: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_take) |=> !out_valid);

  // R10
  a_r10_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(~slot_vacant) ==
      $past($countones(~slot_vacant)) + $past(int'(in_valid && in_ready))
      - $past(int'(out_valid && out_take)));

endmodule

bind token_fifo_ctrl tf_checker #(.SLOTS(SLOTS), .WIDTH(WIDTH)) i_tf_checker (.*);

// File: tb/test_token_fifo_ctrl.sv
module test_token_fifo_ctrl;

  localparam int SLOTS = 4;
  localparam int WIDTH = 8;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [WIDTH-1:0] in_data;
  logic             in_ready;
  logic             out_valid;
  logic             out_take;
  logic [WIDTH-1:0] out_data;
  logic [SLOTS-1:0] slot_vacant;

  int               checks;
  int               errors;
  int               cycles;
  bit               mon_en;
  logic [WIDTH-1:0] model_q[$];

  token_fifo_ctrl #(.SLOTS(SLOTS), .WIDTH(WIDTH), .RESET_CYCLES(3)) i_token_fifo_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_take    (out_take),
    .out_data    (out_data),
    .slot_vacant (slot_vacant)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int occupied();
    int n = 0;
    for (int k = 0; k < SLOTS; k++) if (!slot_vacant[k]) n++;
    return n;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference model: a queue of accepted words, checked once per cycle.
  always begin
    @(negedge clk);
    #1;
    if (mon_en) begin
      check_eq("R10 occupied slots vs model", occupied(), model_q.size());
      if (out_valid && model_q.size() > 0)
        check_eq("R3 R10 head word", int'(out_data), int'(model_q[0]));
      if (out_valid && out_take && model_q.size() > 0) void'(model_q.pop_front());
      if (in_valid && in_ready) model_q.push_back(in_data);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic push(input logic [WIDTH-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    cycles   = 0;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    out_take = 1'b0;

    repeat (3) @(negedge clk);
    check_eq("R1 slot_vacant in reset", int'(slot_vacant), 4'hF);
    check_eq("R1 in_ready in reset", int'(in_ready), 1);
    check_eq("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    // Single word through an empty buffer (forward timing)
    in_valid = 1'b1;
    in_data  = 8'hA5;
    @(negedge clk);                       // accept edge a passed
    in_valid = 1'b0;
    in_data  = '0;
    check_eq("R8 R2 slot 0 occupied", int'(slot_vacant), 4'b1110);
    check_eq("R2 in_ready low", int'(in_ready), 0);
    @(negedge clk);                       // a+1
    check_eq("R6 word still in slot 0", int'(slot_vacant), 4'b1110);
    @(negedge clk);                       // a+2
    check_eq("R4 R6 word moved to slot 1", int'(slot_vacant), 4'b1101);
    repeat (3) @(negedge clk);            // a+5
    check_eq("R6 word in slot 2", int'(slot_vacant), 4'b1011);
    check_eq("R6 out_valid not yet", int'(out_valid), 0);
    @(negedge clk);                       // a+6
    check_eq("R6 out_valid after 2*(SLOTS-1)", int'(out_valid), 1);
    check_eq("R6 out_data", int'(out_data), 8'hA5);

    out_take = 1'b1;
    @(negedge clk);
    out_take = 1'b0;
    check_eq("R9 take vacates last slot", int'(slot_vacant), 4'hF);

    // Take on an empty buffer is ignored
    out_take = 1'b1;
    repeat (3) @(negedge clk);
    out_take = 1'b0;
    check_eq("R9 take while empty ignored", int'(slot_vacant), 4'hF);

    // Fill completely
    push(8'h11);
    push(8'h22);
    push(8'h33);
    push(8'h44);
    repeat (20) @(negedge clk);
    check_eq("R2 all slots occupied", int'(slot_vacant), 4'h0);
    check_eq("R2 in_ready low when full", int'(in_ready), 0);

    // Offer while full is ignored
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    check_eq("R8 offer while full ignored", int'(slot_vacant), 4'h0);
    check_eq("R8 R3 head unchanged", int'(out_data), 8'h11);

    // Hole travels backwards; second take exposes the hop hold-off
    out_take = 1'b1;
    @(negedge clk);                       // take edge s
    out_take = 1'b0;
    check_eq("R9 last slot vacated", int'(slot_vacant), 4'b1000);
    @(negedge clk);                       // s+1
    check_eq("R7 out_valid back next edge", int'(out_valid), 1);
    check_eq("R7 R4 hole in slot 2", int'(slot_vacant), 4'b0100);
    check_eq("R7 next word", int'(out_data), 8'h22);
    out_take = 1'b1;
    @(negedge clk);                       // s+2
    out_take = 1'b0;
    check_eq("R7 pattern after second take", int'(slot_vacant), 4'b1010);
    check_eq("R7 in_ready still low", int'(in_ready), 0);
    @(negedge clk);                       // s+3
    check_eq("R7 in_ready after SLOTS-1 edges", int'(in_ready), 1);
    check_eq("R7 pattern", int'(slot_vacant), 4'b1001);
    @(negedge clk);                       // s+4
    check_eq("R5 last hop still holding off", int'(out_valid), 0);
    @(negedge clk);                       // s+5
    check_eq("R5 last hop fires after hold", int'(out_valid), 1);
    check_eq("R5 word", int'(out_data), 8'h33);

    // Drain
    out_take = 1'b1;
    repeat (30) @(negedge clk);
    out_take = 1'b0;
    check_eq("R10 drained", int'(slot_vacant), 4'hF);

    // Random streaming in three stall mixes
    for (int ph = 0; ph < 3; ph++) begin
      int pin;
      int pout;
      pin  = (ph == 0) ? 70 : (ph == 1) ? 30 : 90;
      pout = (ph == 0) ? 40 : (ph == 1) ? 80 : 90;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        in_valid = ($urandom % 100) < pin;
        in_data  = WIDTH'($urandom);
        out_take = ($urandom % 100) < pout;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_take = 1'b1;
    repeat (40) @(negedge clk);
    out_take = 1'b0;
    @(negedge clk);
    check_eq("R10 all words delivered", model_q.size(), 0);
    check_eq("R10 buffer empty at end", int'(slot_vacant), 4'hF);

    finish_run();
  end

endmodule